// File: doc/BRIEF.md
# Zero-Suppressed Front Data Packer

This block builds the front data block of one bunch crossing. It takes fifteen muon stub slots. The slots form five groups of three, and each group belongs to one front FPGA. On a start strobe the block samples the frames, the valid-pattern bits, the sync-error bits and the configuration into its own registers. It then streams 16-bit words to a downstream consumer over a valid/ready handshake, and it marks the final word of the block with a last flag.

The block opens with two flag words: the valid-pattern word, then the sync-error word. Bits of slots whose FPGA is masked off are cleared in both words. Next come the stub frames: two words per chosen slot, frame 1 first, then frame 2. Slots are visited in ascending order. With zero suppression off, a slot is chosen when its FPGA is active. With zero suppression on, a slot is chosen only when its FPGA is active and its valid-pattern bit is set. If the crossing count is zero, or every FPGA is masked off, a start produces no words at all.

Top module: `front_blk_packer`

## Requirements
- R1: A start while the crossing count is zero or the FPGA activity mask is all zero emits no word; a start that arrives while a block is being emitted is ignored.
- R2: The first word of a block holds the valid-pattern bits of slots 0..14 in bits 0..14, with bit 15 zero.
- R3: The second word holds the sync-error bits in the same bit positions, with bit 15 zero.
- R4: Slot s belongs to FPGA mask bit s/3, so mask bit 0 covers slots 0–2 and mask bit 4 covers slots 12–14. Both flag bits of a slot whose FPGA bit is 0 are output as zero.
- R5: With zero suppression off (zs_en_i = 0), every slot of every active FPGA emits its frames.
- R6: With zero suppression on (zs_en_i = 1), only slots that are active and have valid-pattern bit 1 emit frames.
- R7: Each emitted slot gives frame 1 and then frame 2, and slots go from slot 0 up to slot 14. Frame f (0 or 1) of slot s is taken from frames_i bits [(2s+f)*16 +: 16].
- R8: out_last_o is high only on the final word of a block. A block is 2 to 32 words long.
- R9: While out_valid_o is high and out_ready_i is low, the data and last outputs hold steady and no word is lost.
- R10: Inputs are sampled at an accepted start. Later changes to frames, flags or configuration do not change the block being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe for one crossing |
| nbx_i | input | 3 | Crossing count; zero suppresses the block |
| fpga_act_i | input | 5 | Front FPGA activity mask |
| zs_en_i | input | 1 | Zero-suppression enable |
| vp_i | input | 15 | Valid-pattern bit per slot |
| se_i | input | 15 | Sync-error bit per slot |
| frames_i | input | 480 | Two 16-bit frames per slot |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer ready |
| out_data_o | output | 16 | Output word |
| out_last_o | output | 1 | Final word of the block |

## Verification
The bench sweeps all 32 activity masks. Each mask is run with both suppression modes, full, empty and mixed valid patterns, and crossing counts that include zero.

- A design that looks up the wrong FPGA for a slot would leak flag bits or frames of a masked group.
- A design that ignores the suppression mode would emit too many or too few frames.
- A design that mishandles the all-empty suppressed case would skip the last flag on the sync-error word, or emit stray frames after it.
- Some runs change the inputs after start and fire a second start in the middle of the block. A design that does not sample its inputs, or that restarts while busy, would emit words that differ from the expected ones.
- A pseudo-random ready pattern exposes any word that is dropped or changes during a stall.

// File: rtl/dp_pkg.sv
// Shared types for the front data packer.
package dp_pkg;
    // Emission phase of one block.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_VP   = 2'd1,
        ST_SE   = 2'd2,
        ST_DATA = 2'd3
    } pk_state_t;
endpackage

// File: rtl/dp_slot_select.sv
// Slot selection: expands the per-FPGA activity mask to the slots and
// works out which slots emit frames.
// Assumes the slots of one FPGA are consecutive, in groups of SLOTS_PER_FPGA.
module dp_slot_select #(
    parameter int N_FPGA         = 5,
    parameter int SLOTS_PER_FPGA = 3,
    localparam int N_SLOTS       = N_FPGA * SLOTS_PER_FPGA
) (
    input  logic [N_FPGA-1:0]  act_mask_i,
    input  logic               zs_en_i,
    input  logic [N_SLOTS-1:0] vp_i,
    output logic [N_SLOTS-1:0] slot_act_o,
    output logic [N_SLOTS-1:0] vp_masked_o,
    output logic [N_SLOTS-1:0] sel_o
);
    // Map each slot to the activity bit of its FPGA.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        assign slot_act_o[s] = act_mask_i[s / SLOTS_PER_FPGA];
    end

    // Clear the valid bits of inactive slots; suppression keeps only valid slots.
    always_comb begin
        vp_masked_o = vp_i & slot_act_o;
        sel_o       = zs_en_i ? vp_masked_o : slot_act_o;
    end
endmodule

// File: rtl/dp_first_set.sv
// Priority picker: returns the index of the lowest set bit.
// Assumes the caller only uses the index when the vector is not zero.
module dp_first_set #(
    parameter int N     = 15,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top down so that the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/front_blk_packer.sv
// Front data block packer for one crossing.
// On an accepted start it samples the inputs, then emits the valid-pattern
// word, the sync-error word and two frames per chosen slot, in ascending
// slot order, over valid/ready.
// Assumes WORD_W > N_SLOTS, so the flag words have a spare zero MSB.
module front_blk_packer #(
    parameter int N_FPGA         = 5,
    parameter int SLOTS_PER_FPGA = 3,
    parameter int WORD_W         = 16,
    parameter int BX_W           = 3,
    localparam int N_SLOTS       = N_FPGA * SLOTS_PER_FPGA,
    localparam int FRM_PER       = 2,
    localparam int FRM_BITS      = N_SLOTS * FRM_PER * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [BX_W-1:0]     nbx_i,
    input  logic [N_FPGA-1:0]   fpga_act_i,
    input  logic                zs_en_i,
    input  logic [N_SLOTS-1:0]  vp_i,
    input  logic [N_SLOTS-1:0]  se_i,
    input  logic [FRM_BITS-1:0] frames_i,
    output logic                out_valid_o,
    input  logic                out_ready_i,
    output logic [WORD_W-1:0]   out_data_o,
    output logic                out_last_o
);
    import dp_pkg::*;

    localparam int IDX_W = $clog2(N_SLOTS);

    pk_state_t           state_q;
    logic [FRM_BITS-1:0] frames_q;
    logic [N_SLOTS-1:0]  vp_q, se_q, pend_q;
    logic                frm_q;

    logic [N_SLOTS-1:0]  slot_act, vp_masked, sel;
    logic [IDX_W-1:0]    cur_idx;
    logic                accept, hs, one_left;

    dp_slot_select #(
        .N_FPGA         (N_FPGA),
        .SLOTS_PER_FPGA (SLOTS_PER_FPGA)
    ) u_sel (
        .act_mask_i  (fpga_act_i),
        .zs_en_i     (zs_en_i),
        .vp_i        (vp_i),
        .slot_act_o  (slot_act),
        .vp_masked_o (vp_masked),
        .sel_o       (sel)
    );

    dp_first_set #(.N(N_SLOTS)) u_pick (
        .vec_i (pend_q),
        .idx_o (cur_idx)
    );

    // Control decodes: accepted start, handshake, and one slot remaining.
    always_comb begin
        accept   = (state_q == ST_IDLE) && start_i && (nbx_i != '0) && (fpga_act_i != '0);
        hs       = out_valid_o && out_ready_i;
        one_left = (pend_q & (pend_q - N_SLOTS'(1))) == '0;
    end

    // Output word mux and last flag, driven from the registered state.
    always_comb begin
        out_valid_o = (state_q != ST_IDLE);
        out_data_o  = '0;
        out_last_o  = 1'b0;
        unique case (state_q)
            ST_VP:   out_data_o = WORD_W'(vp_q);
            ST_SE: begin
                out_data_o = WORD_W'(se_q);
                out_last_o = (pend_q == '0);
            end
            ST_DATA: begin
                out_data_o = frames_q[(32'(cur_idx) * FRM_PER + 32'(frm_q)) * WORD_W +: WORD_W];
                out_last_o = frm_q && one_left;
            end
            default: ;
        endcase
    end

    // Sequencer: samples the inputs on start and steps on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            frames_q <= '0;
            vp_q     <= '0;
            se_q     <= '0;
            pend_q   <= '0;
            frm_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    frames_q <= frames_i;
                    vp_q     <= vp_masked;
                    se_q     <= se_i & slot_act;
                    pend_q   <= sel;
                    frm_q    <= 1'b0;
                    state_q  <= ST_VP;
                end
                ST_VP:   if (hs) state_q <= ST_SE;
                ST_SE:   if (hs) state_q <= (pend_q == '0) ? ST_IDLE : ST_DATA;
                ST_DATA: if (hs) begin
                    if (!frm_q) begin
                        frm_q <= 1'b1;
                    end else begin
                        frm_q  <= 1'b0;
                        pend_q <= pend_q & ~(N_SLOTS'(1) << cur_idx);
                        if (one_left) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dp_packer_chk.sv
// Protocol checker for the packer's output stream. It is attached to
// front_blk_packer by the bind statement at the end of this file.
module dp_packer_chk #(
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 32,
    localparam int CNT_W    = $clog2(MAX_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid_o,
    input logic              out_ready_i,
    input logic              out_last_o,
    input logic [WORD_W-1:0] out_data_o
);
    logic [CNT_W-1:0] cnt_q;

    // Counts the words already accepted in the current block.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cnt_q <= '0;
        else if (out_valid_o && out_ready_i)            cnt_q <= out_last_o ? '0 : cnt_q + CNT_W'(1);
    end

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));
    a_r8_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last_o |-> out_valid_o);
    a_r8_len_max: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> cnt_q < CNT_W'(MAX_WORDS));
    a_r8_len_min: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_last_o |-> cnt_q >= CNT_W'(1));
    a_r1_gap_after_block: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);
    a_r2_flag_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && cnt_q < CNT_W'(2) |-> !out_data_o[WORD_W-1]);
endmodule

bind front_blk_packer dp_packer_chk #(
    .WORD_W    (WORD_W),
    .MAX_WORDS (2 + FRM_PER * N_SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_last_o  (out_last_o),
    .out_data_o  (out_data_o)
);

// File: tb/tb_front_blk_packer.sv
// Sweep bench for front_blk_packer. Expected words are computed from the
// requirements.
module tb_front_blk_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [2:0]   nbx_i = '0;
    logic [4:0]   fpga_act_i = '0;
    logic         zs_en_i = 1'b0;
    logic [14:0]  vp_i = '0, se_i = '0;
    logic [479:0] frames_i = '0;
    logic         out_valid_o, out_ready_i = 1'b0, out_last_o;
    logic [15:0]  out_data_o;

    int n_tests = 0, n_fail = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [15:0] exp_w [0:31];

    always #5 clk = ~clk;

    front_blk_packer dut (.*);

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            n_fail = n_fail + 1;
            n_tests = n_tests + 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] fv(int s, int f, int seed);
        return 16'((seed * 97 + s * 13 + f * 5) ^ (s << 11));
    endfunction

    task automatic load(input int seed);
        for (int s = 0; s < 15; s++)
            for (int f = 0; f < 2; f++)
                frames_i[(s*2+f)*16 +: 16] = fv(s, f, seed);
    endtask

    task automatic run_case(input logic [4:0] mask, input bit zs, input logic [14:0] vp,
                            input logic [14:0] se, input logic [2:0] nbx, input int seed, input bit disturb);
        logic [14:0] act, sel;
        int n, got, guard;
        bit stall;
        logic [15:0] pdata;
        logic plast;
        for (int s = 0; s < 15; s++) act[s] = mask[s/3];            // R4 grouping
        sel = zs ? (vp & act) : act;                                 // R5, R6
        n = 0;
        if (nbx != 0 && mask != 0) begin
            exp_w[0] = {1'b0, vp & act};                             // R2
            exp_w[1] = {1'b0, se & act};                             // R3
            n = 2;
            for (int s = 0; s < 15; s++)
                if (sel[s]) begin                                    // R7 order
                    exp_w[n] = fv(s, 0, seed);
                    exp_w[n+1] = fv(s, 1, seed);
                    n += 2;
                end
        end
        @(negedge clk);
        fpga_act_i = mask; zs_en_i = zs; vp_i = vp; se_i = se; nbx_i = nbx; load(seed);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (disturb) begin                                           // R10: change inputs after start
            load(seed + 1); vp_i = ~vp; se_i = ~se; fpga_act_i = ~mask; zs_en_i = ~zs; nbx_i = 3'd7;
        end
        got = 0; guard = 0; stall = 0; pdata = '0; plast = 1'b0;
        while (guard < 200 && (n == 0 ? guard < 6 : got < n)) begin
            if (n == 0) check(!out_valid_o, "R1 empty", {15'b0, out_valid_o}, 16'h0);
            if (stall) check(out_valid_o && out_data_o == pdata && out_last_o == plast, "R9 hold", out_data_o, pdata);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready_i = (lfsr[1:0] != 2'b00);
            start_i = disturb && got == 3;                            // R1: start while busy is ignored
            stall = out_valid_o && !out_ready_i;
            pdata = out_data_o; plast = out_last_o;
            if (out_valid_o && out_ready_i) begin
                if (got < n) begin
                    check(out_data_o == exp_w[got], got < 2 ? (got == 0 ? "R2 vp word" : "R3 se word") : "R7 frame",
                          out_data_o, exp_w[got]);
                    check(out_last_o == (got == n - 1), "R8 last", {15'b0, out_last_o}, {15'b0, got == n - 1});
                end else check(1'b0, "R8 extra word", out_data_o, 16'h0);
                got++;
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        out_ready_i = 1'b0;
        check(got == n, "R8 length", 16'(got), 16'(n));
        check(!out_valid_o, "R1 idle after block", {15'b0, out_valid_o}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!out_valid_o && !out_last_o, "R8 reset state", {15'b0, out_valid_o}, 16'h0);
        rst_n = 1'b1;
        for (int m = 0; m < 32; m++)
            for (int z = 0; z < 2; z++)
                for (int p = 0; p < 3; p++) begin
                    logic [14:0] vp;
                    vp = (p == 0) ? 15'h7fff : (p == 1) ? 15'h0000 : 15'(15'h2a5b ^ (m * 1111));
                    run_case(5'(m), z[0], vp, 15'(~vp ^ 15'h1234), 3'((m + p) % 8),
                             m * 7 + p, (m % 3) == 0);
                end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule